// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block expands a compressed byte stream of programmable-logic configuration data into a serial stream of single bits. Every byte before the start marker is thrown away. The marker is a 0xFF byte followed directly by a byte whose upper nibble is 3. After the marker, the block sends a fixed 16-bit synchronisation word. It then turns each following byte into a run of ones or zeros, using a four-range code that favours long runs of ones.

Both sides are ready/valid streams. The input is a byte with a last flag. The output is one bit with a last flag, and the configuration sequencer behind the block reads it at whatever pace it can. When a byte flagged last has been fully expanded, the block goes back to searching for a marker, so the next stream can follow straight away.

The longest run of ones is the parameter `MAX_ONES`, default 226. The code ranges below are given for M = `MAX_ONES`, with the default values in brackets.

Top module: `rlbit_unpack`

## Requirements
- R1: While the block is searching for the marker, it accepts every input byte (`in_ready` is high), produces no output bit (`out_valid` is low), and discards every byte. After reset it is searching.
- R2: The marker is a byte equal to 0xFF followed directly by a byte in 0x30..0x3F. Several 0xFF bytes in a row still arm the search. A byte flagged last while searching clears the search, so that byte cannot be the first half of a marker. Decoding starts with the byte after the marker.
- R3: After the marker and before any decoded bit, the output carries 16 bits, most significant first: 1111_1111_0010_0000 (0xFF then 0x20). `out_last` stays low during these bits.
- R4: A code byte n with 1 <= n <= M [226] expands to n ones followed by one zero.
- R5: The code byte M+1 [227] expands to M [226] ones with no zero after them.
- R6: A code byte n with M+2 <= n <= 254 [228..254] expands to n-(M+2) zeros followed by one one. So M+2 [228] gives a single one.
- R7: The code byte 255 expands to a single one.
- R8: The code byte 0 produces no bits. Decoding continues with the next byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` keep their values. No bit is lost or repeated across a stall.
- R10: `out_last` is high on exactly the last bit expanded from a byte flagged last, and on no other bit. If that byte is 0, no bit carries the flag. After such a byte, the block searches for a new marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Compressed byte |
| in_valid | input | 1 | Input byte present |
| in_last | input | 1 | Input byte is the final byte of its stream |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_bit | output | 1 | Expanded configuration bit |
| out_valid | output | 1 | Output bit present |
| out_last | output | 1 | Output bit is the final bit of the stream |
| out_ready | input | 1 | Consumer accepts the output bit this cycle |

## Verification
The bench goes after the range edges of the code: 1, 226, 227, 228, 229, 254, 255 and 0.
- A decoder that is off by one at the 226/227 boundary would add a stray zero after the long run.
- A decoder that mishandles 228 would emit a zero before the single one.
- A decoder that mishandles 0 would emit a phantom bit.

For the marker search, the bench sends a 0x3X byte that does not follow 0xFF, a pair of 0xFF bytes, and a 0xFF byte flagged last followed by 0x30. A search that does not clear or re-arm correctly would start decoding at the wrong byte, which shows up as a misplaced synchronisation word.

Random output stalls, a last byte of code 0, and two streams sent back to back check that stalls neither drop nor duplicate bits, and that the last flag lands only on the true final bit.

// File: rtl/rlbit_pkg.sv
package rlbit_pkg;

   // one decoded code byte: a run of identical bits plus an optional closing bit
   typedef struct packed {
      logic [7:0] len;
      logic       run_bit;
      logic       has_tail;
      logic       tail_bit;
   } run_desc_t;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_SYNC  = 2'd1,
      ST_DATA  = 2'd2,
      ST_DRAIN = 2'd3
   } phase_t;

   localparam logic [7:0]  MARK_LEAD = 8'hFF;
   localparam logic [3:0]  MARK_TAG  = 4'h3;
   localparam logic [15:0] SYNC_WORD = 16'hFF20;

endpackage

// File: rtl/rlbit_code_map.sv
module rlbit_code_map
   import rlbit_pkg::*;
#(
   parameter int MAX_ONES = 226
) (
   input  logic [7:0] code,
   output run_desc_t  desc
);

   localparam logic [7:0] ONES_LIM  = 8'(MAX_ONES);
   localparam logic [7:0] FULL_CODE = 8'(MAX_ONES + 1);
   localparam logic [7:0] ZERO_BASE = 8'(MAX_ONES + 2);

   generate
      if (MAX_ONES < 1 || MAX_ONES > 252) begin : g_bad_limit
         $error("rlbit_code_map: MAX_ONES must lie in 1..252");
      end
   endgenerate

   always_comb begin
      desc = '0;
      if (code == 8'd0) begin
         desc = '0;
      end else if (code <= ONES_LIM) begin
         desc.len      = code;
         desc.run_bit  = 1'b1;
         desc.has_tail = 1'b1;
         desc.tail_bit = 1'b0;
      end else if (code == FULL_CODE) begin
         desc.len      = ONES_LIM;
         desc.run_bit  = 1'b1;
      end else if (code != 8'hFF) begin
         desc.len      = code - ZERO_BASE;
         desc.run_bit  = 1'b0;
         desc.has_tail = 1'b1;
         desc.tail_bit = 1'b1;
      end else begin
         desc.has_tail = 1'b1;
         desc.tail_bit = 1'b1;
      end
   end

endmodule

// File: rtl/rlbit_run_emitter.sv
module rlbit_run_emitter
   import rlbit_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  run_desc_t desc,
   input  logic      load_last,
   input  logic      out_ready,
   output logic      busy,
   output logic      bit_o,
   output logic      last_o,
   output logic      done_o
);

   logic [7:0] cnt_q;
   logic       run_bit_q;
   logic       tail_q;
   logic       tail_bit_q;
   logic       last_q;
   logic       final_bit;

   assign busy      = (cnt_q != 8'd0) || tail_q;
   assign final_bit = ((cnt_q == 8'd1) && !tail_q) || ((cnt_q == 8'd0) && tail_q);
   assign bit_o     = (cnt_q != 8'd0) ? run_bit_q : tail_bit_q;
   assign last_o    = last_q && final_bit;
   assign done_o    = busy && final_bit && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         run_bit_q  <= 1'b0;
         tail_q     <= 1'b0;
         tail_bit_q <= 1'b0;
         last_q     <= 1'b0;
      end else if (load) begin
         cnt_q      <= desc.len;
         run_bit_q  <= desc.run_bit;
         tail_q     <= desc.has_tail;
         tail_bit_q <= desc.tail_bit;
         last_q     <= load_last;
      end else if (busy && out_ready) begin
         if (cnt_q != 8'd0) cnt_q  <= cnt_q - 8'd1;
         else               tail_q <= 1'b0;
      end
   end

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !out_ready && !load |=> busy && $stable(bit_o) && $stable(last_o)); // R9

   AST_FINAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      busy && out_ready && final_bit && !load |=> !busy); // R10

endmodule

// File: rtl/rlbit_unpack.sv
module rlbit_unpack
   import rlbit_pkg::*;
#(
   parameter int MAX_ONES = 226
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   input  logic       in_last,
   output logic       in_ready,
   output logic       out_bit,
   output logic       out_valid,
   output logic       out_last,
   input  logic       out_ready
);

   localparam int SYNC_W = $bits(SYNC_WORD);
   localparam int IDX_W  = $clog2(SYNC_W);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(SYNC_W - 1);

   phase_t            st_q;
   logic              prev_ff_q;
   logic [SYNC_W-1:0] sync_sr_q;
   logic [IDX_W-1:0]  sync_idx_q;

   run_desc_t desc;
   logic      em_load, em_busy, em_bit, em_last, em_done;
   logic      accept, marker_hit;

   rlbit_code_map #(.MAX_ONES(MAX_ONES)) i_map (
      .code (in_data),
      .desc (desc)
   );

   rlbit_run_emitter i_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (em_load),
      .desc      (desc),
      .load_last (in_last),
      .out_ready (out_ready),
      .busy      (em_busy),
      .bit_o     (em_bit),
      .last_o    (em_last),
      .done_o    (em_done)
   );

   always_comb begin
      case (st_q)
         ST_HUNT: in_ready = 1'b1;
         ST_DATA: in_ready = !em_busy || em_done;
         default: in_ready = 1'b0;
      endcase
   end

   assign accept     = in_valid && in_ready;
   assign em_load    = accept && (st_q == ST_DATA);
   assign marker_hit = accept && (st_q == ST_HUNT) && prev_ff_q && !in_last &&
                       (in_data[7:4] == MARK_TAG);

   assign out_valid  = (st_q == ST_SYNC) || em_busy;
   assign out_bit    = (st_q == ST_SYNC) ? sync_sr_q[SYNC_W-1] : em_bit;
   assign out_last   = (st_q == ST_SYNC) ? 1'b0 : em_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_HUNT;
         prev_ff_q  <= 1'b0;
         sync_sr_q  <= '0;
         sync_idx_q <= '0;
      end else begin
         case (st_q)
            ST_HUNT: begin
               if (marker_hit) begin
                  st_q       <= ST_SYNC;
                  sync_sr_q  <= SYNC_WORD;
                  sync_idx_q <= '0;
                  prev_ff_q  <= 1'b0;
               end else if (accept) begin
                  prev_ff_q <= !in_last && (in_data == MARK_LEAD);
               end
            end
            ST_SYNC: begin
               if (out_ready) begin
                  sync_sr_q  <= {sync_sr_q[SYNC_W-2:0], 1'b0};
                  sync_idx_q <= sync_idx_q + IDX_W'(1);
                  if (sync_idx_q == IDX_END) st_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (em_load && in_last) st_q <= ST_DRAIN;
            end
            default: begin
               if (!em_busy) st_q <= ST_HUNT;
            end
         endcase
      end
   end

   AST_QUIET_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HUNT) |-> !out_valid); // R1

   AST_SYNC_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SYNC) && out_ready && (sync_idx_q == IDX_END) |=> (st_q == ST_DATA) && !out_valid); // R3

   AST_OUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_bit)); // R9

   AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid); // R10

endmodule

// File: tb/test_rlbit_unpack.sv
module test_rlbit_unpack;

   localparam int CLK_PERIOD = 10;
   localparam int M          = 226;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       out_bit;
   logic       out_valid;
   logic       out_last;
   logic       out_ready = 1'b0;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  stall_en = 1'b0;
   bit  collect_on = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   bit got_bits[$];
   bit got_last[$];
   bit exp_bits[$];
   bit exp_last[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rlbit_unpack #(.MAX_ONES(M)) i_rlbit_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_ready  (in_ready),
      .out_bit   (out_bit),
      .out_valid (out_valid),
      .out_last  (out_last),
      .out_ready (out_ready)
   );

   // consumer: pick ready at the falling edge, record a transfer just after
   initial begin
      forever begin
         @(negedge clk);
         lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         out_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
         #1;
         if (collect_on && out_valid && out_ready) begin
            got_bits.push_back(out_bit);
            got_last.push_back(out_last);
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int actual, input int expected);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit last);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      in_last  = last;
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      @(posedge clk);
   endtask

   task automatic idle_input();
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 30) begin
         @(negedge clk);
         #2;
         if (out_valid) q = 0;
         else q++;
      end
   endtask

   task automatic exp_push(input bit b, input bit l);
      exp_bits.push_back(b);
      exp_last.push_back(l);
   endtask

   task automatic exp_sync();
      logic [15:0] w = 16'b1111_1111_0010_0000;
      for (int i = 15; i >= 0; i--) exp_push(w[i], 1'b0);
   endtask

   // expected expansion written from the code ranges of R4..R8
   task automatic exp_code(input int n, input bit last);
      bit seq[$];
      if (n >= 1 && n <= M) begin
         for (int i = 0; i < n; i++) seq.push_back(1'b1);
         seq.push_back(1'b0);
      end else if (n == M + 1) begin
         for (int i = 0; i < M; i++) seq.push_back(1'b1);
      end else if (n >= M + 2 && n <= 254) begin
         for (int i = 0; i < n - (M + 2); i++) seq.push_back(1'b0);
         seq.push_back(1'b1);
      end else if (n == 255) begin
         seq.push_back(1'b1);
      end
      for (int i = 0; i < seq.size(); i++)
         exp_push(seq[i], last && (i == seq.size() - 1));
   endtask

   task automatic compare(input string req);
      int bad = -1;
      int badl = -1;
      check(got_bits.size() == exp_bits.size(), req, "bit count",
            got_bits.size(), exp_bits.size());
      if (got_bits.size() == exp_bits.size()) begin
         for (int i = 0; i < exp_bits.size(); i++) begin
            if (bad < 0 && got_bits[i] != exp_bits[i]) bad = i;
            if (badl < 0 && got_last[i] != exp_last[i]) badl = i;
         end
         check(bad < 0, req, $sformatf("bit value at %0d", bad),
               (bad < 0) ? 0 : int'(got_bits[bad]), (bad < 0) ? 0 : int'(exp_bits[bad]));
         check(badl < 0, req, $sformatf("last flag at %0d", badl),
               (badl < 0) ? 0 : int'(got_last[badl]), (badl < 0) ? 0 : int'(exp_last[badl]));
      end
      got_bits.delete(); got_last.delete();
      exp_bits.delete(); exp_last.delete();
   endtask

   // R1: reset state
   task automatic t_reset();
      #1;
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R1", "in_ready while searching", in_ready, 1);
      check(out_last == 1'b0, "R10", "out_last after reset", out_last, 0);
   endtask

   // R1 R2 R3 R4 R7: junk, false markers, doubled lead byte, then a short frame
   task automatic t_hunt();
      send_byte(8'h12, 0); send_byte(8'hFF, 0); send_byte(8'h40, 0);
      send_byte(8'h3F, 0); send_byte(8'hFF, 0); send_byte(8'hFF, 0);
      send_byte(8'h35, 0);
      send_byte(8'd3, 0); send_byte(8'd255, 1);
      idle_input(); wait_quiet();
      exp_sync(); exp_code(3, 0); exp_code(255, 1);
      compare("R2/R3/R4/R7 marker search");
   endtask

   // R4 R5 R6 R7: every range edge
   task automatic t_edges();
      int codes[8] = '{1, 226, 227, 228, 229, 240, 254, 255};
      send_byte(8'hFF, 0); send_byte(8'h30, 0);
      exp_sync();
      foreach (codes[i]) begin
         send_byte(8'(codes[i]), i == 7);
         exp_code(codes[i], i == 7);
      end
      idle_input(); wait_quiet();
      compare("R4/R5/R6/R7 range edges");
   endtask

   // R8 R10: zero codes, the last one flagged
   task automatic t_zero();
      send_byte(8'hFF, 0); send_byte(8'h3A, 0);
      send_byte(8'd5, 0); send_byte(8'd0, 0); send_byte(8'd230, 0);
      send_byte(8'd0, 1);
      idle_input(); wait_quiet();
      exp_sync(); exp_code(5, 0); exp_code(230, 0);
      compare("R8/R10 zero code");
      // stream closed: a fresh marker is required (R10)
      send_byte(8'd2, 0); send_byte(8'hFF, 0); send_byte(8'h31, 0);
      send_byte(8'd2, 1);
      idle_input(); wait_quiet();
      exp_sync(); exp_code(2, 1);
      compare("R10 return to search");
   endtask

   // R9: random output stalls
   task automatic t_stall();
      stall_en = 1'b1;
      send_byte(8'hFF, 0); send_byte(8'h3C, 0);
      send_byte(8'd227, 0); send_byte(8'd2, 0); send_byte(8'd250, 0);
      send_byte(8'd1, 0); send_byte(8'd230, 1);
      idle_input(); wait_quiet();
      stall_en = 1'b0;
      exp_sync(); exp_code(227, 0); exp_code(2, 0); exp_code(250, 0);
      exp_code(1, 0); exp_code(230, 1);
      compare("R9 backpressure");
   endtask

   // R2: a lead byte flagged last does not arm the search
   task automatic t_hunt_last();
      send_byte(8'hFF, 1); send_byte(8'h30, 0); send_byte(8'd7, 0);
      send_byte(8'hFF, 0); send_byte(8'h33, 0); send_byte(8'd4, 1);
      idle_input(); wait_quiet();
      exp_sync(); exp_code(4, 1);
      compare("R2 last clears search");
   endtask

   // R10: two streams back to back with stalls
   task automatic t_two_streams();
      stall_en = 1'b1;
      send_byte(8'hFF, 0); send_byte(8'h30, 0); send_byte(8'd7, 1);
      send_byte(8'hFF, 0); send_byte(8'h3F, 0); send_byte(8'd255, 1);
      idle_input(); wait_quiet();
      stall_en = 1'b0;
      exp_sync(); exp_code(7, 1); exp_sync(); exp_code(255, 1);
      compare("R10 back-to-back streams");
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      collect_on = 1'b1;
      t_hunt();
      t_edges();
      t_zero();
      t_stall();
      t_hunt_last();
      t_two_streams();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule